// File: doc/BRIEF.md
# Register-Programmed SPI Master with Run-Time Pin Routing

This block is an SPI master whose clock, data-out, data-in and chip-select signals appear on general-purpose I/O lines that software picks while the system is running. Two 12-line GPIO ports are available, giving 24 candidate pins. Four per-target setup words each describe one SPI target. A setup word holds the pin numbers for the four SPI signals, the SCLK edge on which outgoing data changes, the SCLK edge on which incoming data is sampled, and the number of bits per transfer.

A shared transaction word chooses which setup the next transfer uses and sets the SCLK divider. Writing a payload to the go word starts a transfer. A status word then reports whether the engine is free and holds the bits captured during the most recent finished transfer.

Software reaches the block through a plain 32-bit register port. That port takes a word address, so byte offset / 4 is the address. Reads return data one clock after the read strobe.

Top module: `gpio_spi_master`

## Requirements
- R1: Word addresses 0..3 hold the four setup words; only bits 27:0 are stored and bits 31:28 read 0. Word 4 is the transaction word; only bits 17:0 are stored. Word 5 is the go word and reads 0. All stored bits reset to 0.
- R2: Word 6 is the status word. Bit 24 is 1 while the engine can accept a transfer, and bits 23:0 hold the last response. Right after reset it reads 0x01000000.
- R3: A write to word 5 while ready is 1 starts a transfer that uses the setup chosen by transaction bits 17:16, and ready reads 0 from the following cycle onward.
- R4: A write to word 5 while ready is 0 is discarded: no extra transfer runs and the response is not disturbed.
- R5: Chip-select is active low and stays low for the whole transfer. SCLK rests low whenever chip-select is high. A transfer of N bits produces exactly N rising and N falling SCLK edges.
- R6: Payload bits leave MSB first, starting at bit 31. Setup bit 27 = 0 makes the outgoing line change on falling SCLK edges, with the first bit valid from the moment chip-select falls. Setup bit 27 = 1 makes it change on rising edges.
- R7: Setup bit 26 = 1 samples the incoming line on rising SCLK edges; 0 samples it on falling edges.
- R8: Captured bits shift in MSB first and end up right-aligned in status bits 23:0. Only the latest 24 bits are kept, and the upper bits are zero for short transfers. The status updates when chip-select rises.
- R9: Setup bits 4:0, 9:5, 14:10 and 19:15 are the pin numbers for SCLK, data-out, data-in and chip-select. Numbers 0..11 select port A lines 0..11 and 16..27 select port B lines 0..11. Any other number leaves that signal unconnected.
- R10: Only the SCLK, data-out and chip-select lines of the active setup have their output enable set; the data-in line stays an input. The active setup is the one used by the last accepted go write, or setup 0 after reset.
- R11: Transaction bits 15:0 (D) set an SCLK period of D+1 core cycles; D = 0 behaves as D = 1.
- R12: Setup bits 25:20 give the bit count. A count of 0 pulses chip-select low with no SCLK edges and leaves a response of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| gpio_a_in | input | 12 | Port A input levels |
| gpio_a_out | output | 12 | Port A output levels |
| gpio_a_oe | output | 12 | Port A output enables |
| gpio_b_in | input | 12 | Port B input levels |
| gpio_b_out | output | 12 | Port B output levels |
| gpio_b_oe | output | 12 | Port B output enables |

## Verification
The bench exercises all four combinations of edge settings against a target model that drives and samples only on the edges the setup names. If an edge polarity were swapped, the model would capture a shifted payload or the status would hold a misaligned response. A 32-bit transfer checks that only the latest 24 received bits are kept, and a design that kept the earliest bits would report the wrong word. The bench also issues a second go write in the middle of a transfer, a zero-length transfer, an odd divider with the divide-by-zero case, and a setup with an out-of-range chip-select number. A design that failed any of these would respectively start a second transfer or overwrite the response, emit stray SCLK edges, produce a wrong SCLK period, or drive a pin it should have left floating.

// File: rtl/gspi_pkg.sv
package gspi_pkg;

  typedef struct packed {
    logic [4:0] cs_pin;
    logic [4:0] miso_pin;
    logic [4:0] mosi_pin;
    logic [4:0] clk_pin;
  } pinmap_t;

  typedef struct packed {
    logic       mosi_rise;
    logic       miso_rise;
    logic [5:0] nbits;
    pinmap_t    map;
  } setup_t;

  localparam int SETUP_W    = $bits(setup_t);
  localparam int WORD_TCFG  = 4;
  localparam int WORD_GO    = 5;
  localparam int WORD_STAT  = 6;
  localparam int READY_BIT  = 24;
  localparam int SEL_LSB    = 16;
  localparam int PORTB_BASE = 16;

  function automatic logic [4:0] pin_code(input int p, input int port_w);
    if (p < port_w) return 5'(p);
    return 5'(PORTB_BASE + p - port_w);
  endfunction

endpackage

// File: rtl/gspi_regs.sv
module gspi_regs
  import gspi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int RESP_W = 24,
  parameter int NSLV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic [RESP_W-1:0] resp,
  output logic              go,
  output logic              go_mosi_rise,
  output logic              go_miso_rise,
  output logic [5:0]        go_nbits,
  output logic [DIV_W-1:0]  go_div,
  output pinmap_t           act_map
);
  localparam int SW = $clog2(NSLV);

  setup_t            setup_q [NSLV];
  logic [SW-1:0]     sel_q;
  logic [SW-1:0]     act_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] status_w;
  setup_t            go_setup;

  assign go       = reg_wr && (int'(reg_addr) == WORD_GO) && !busy;
  assign go_setup = setup_q[sel_q];
  assign go_mosi_rise = go_setup.mosi_rise;
  assign go_miso_rise = go_setup.miso_rise;
  assign go_nbits     = go_setup.nbits;
  assign go_div       = div_q;
  assign act_map      = setup_q[act_q].map;

  always_comb begin
    status_w = '0;
    status_w[READY_BIT]  = !busy;
    status_w[RESP_W-1:0] = resp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLV; i++) setup_q[i] <= '0;
      sel_q <= '0;
      act_q <= '0;
      div_q <= '0;
    end else begin
      if (reg_wr && int'(reg_addr) < NSLV)
        setup_q[reg_addr[SW-1:0]] <= setup_t'(reg_wdata[SETUP_W-1:0]);
      if (reg_wr && int'(reg_addr) == WORD_TCFG) begin
        sel_q <= reg_wdata[SEL_LSB +: SW];
        div_q <= reg_wdata[DIV_W-1:0];
      end
      if (go) act_q <= sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      if (int'(reg_addr) < NSLV)
        reg_rdata[SETUP_W-1:0] <= setup_q[reg_addr[SW-1:0]];
      else if (int'(reg_addr) == WORD_TCFG) begin
        reg_rdata[SEL_LSB +: SW] <= sel_q;
        reg_rdata[DIV_W-1:0]     <= div_q;
      end else if (int'(reg_addr) == WORD_STAT)
        reg_rdata <= status_w;
    end
  end
endmodule

// File: rtl/gspi_engine.sv
module gspi_engine #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int RESP_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              mosi_rise,
  input  logic              miso_rise,
  input  logic [5:0]        nbits,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic [RESP_W-1:0] resp
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} state_t;

  state_t            st;
  logic [DIV_W:0]    per_w, hi_w, lo_w;
  logic [DIV_W:0]    cnt, hi_q, lo_q;
  logic [5:0]        left;
  logic [DATA_W-1:0] shreg;
  logic [RESP_W-1:0] rx;
  logic              mr_q, sr_q;

  always_comb begin
    per_w = (div == '0) ? (DIV_W+1)'(2) : ({1'b0, div} + 1'b1);
    hi_w  = per_w >> 1;
    lo_w  = per_w - hi_w;
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1;
      cnt <= '0; hi_q <= '0; lo_q <= '0; left <= '0;
      shreg <= '0; rx <= '0; resp <= '0; mr_q <= 1'b0; sr_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cs_n <= 1'b0;
          rx   <= '0;
          mr_q <= mosi_rise;
          sr_q <= miso_rise;
          hi_q <= hi_w;
          lo_q <= lo_w;
          cnt  <= lo_w;
          left <= nbits;
          if (!mosi_rise) begin
            mosi  <= data[DATA_W-1];
            shreg <= data << 1;
          end else begin
            shreg <= data;
          end
          st <= (nbits == '0) ? S_TAIL : S_RUN;
        end
        S_RUN: begin
          if (cnt > 1) begin
            cnt <= cnt - 1'b1;
          end else begin
            sclk <= !sclk;
            if (!sclk) begin
              cnt <= hi_q;
              if (mr_q) begin mosi <= shreg[DATA_W-1]; shreg <= shreg << 1; end
              if (sr_q) rx <= {rx[RESP_W-2:0], miso};
            end else begin
              cnt  <= lo_q;
              left <= left - 1'b1;
              if (!mr_q) begin mosi <= shreg[DATA_W-1]; shreg <= shreg << 1; end
              if (!sr_q) rx <= {rx[RESP_W-2:0], miso};
              if (left == 6'd1) st <= S_TAIL;
            end
          end
        end
        S_TAIL: begin
          if (cnt > 1) begin
            cnt <= cnt - 1'b1;
          end else begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            resp <= rx;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gspi_pinmux.sv
module gspi_pinmux
  import gspi_pkg::*;
#(
  parameter int PORT_W = 12
) (
  input  pinmap_t           map,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  input  logic [PORT_W-1:0] a_in,
  input  logic [PORT_W-1:0] b_in,
  output logic [PORT_W-1:0] a_out,
  output logic [PORT_W-1:0] a_oe,
  output logic [PORT_W-1:0] b_out,
  output logic [PORT_W-1:0] b_oe,
  output logic              miso
);
  localparam int NPIN = 2 * PORT_W;

  logic [NPIN-1:0] pin_out, pin_oe, pin_in;

  assign pin_in = {b_in, a_in};
  assign a_out  = pin_out[PORT_W-1:0];
  assign b_out  = pin_out[NPIN-1:PORT_W];
  assign a_oe   = pin_oe[PORT_W-1:0];
  assign b_oe   = pin_oe[NPIN-1:PORT_W];

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam logic [4:0] CODE = pin_code(p, PORT_W);
    logic hit_clk, hit_mosi, hit_cs;
    assign hit_clk  = (map.clk_pin  == CODE);
    assign hit_mosi = (map.mosi_pin == CODE);
    assign hit_cs   = (map.cs_pin   == CODE);
    assign pin_oe[p]  = hit_clk | hit_mosi | hit_cs;
    assign pin_out[p] = hit_clk ? sclk : hit_mosi ? mosi : hit_cs ? cs_n : 1'b0;
  end

  always_comb begin
    miso = 1'b0;
    for (int p = 0; p < NPIN; p++)
      if (map.miso_pin == pin_code(p, PORT_W)) miso = pin_in[p];
  end
endmodule

// File: rtl/gpio_spi_master.sv
module gpio_spi_master
  import gspi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int RESP_W = 24,
  parameter int NSLV   = 4,
  parameter int PORT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] gpio_a_in,
  output logic [PORT_W-1:0] gpio_a_out,
  output logic [PORT_W-1:0] gpio_a_oe,
  input  logic [PORT_W-1:0] gpio_b_in,
  output logic [PORT_W-1:0] gpio_b_out,
  output logic [PORT_W-1:0] gpio_b_oe
);
  logic              go, go_mosi_rise, go_miso_rise;
  logic [5:0]        go_nbits;
  logic [DIV_W-1:0]  go_div;
  pinmap_t           act_map;
  logic              eng_sclk, eng_mosi, eng_cs_n, eng_busy, eng_miso;
  logic [RESP_W-1:0] eng_resp;

  gspi_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .RESP_W(RESP_W), .NSLV(NSLV)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(eng_busy), .resp(eng_resp),
    .go(go), .go_mosi_rise(go_mosi_rise), .go_miso_rise(go_miso_rise),
    .go_nbits(go_nbits), .go_div(go_div), .act_map(act_map)
  );

  gspi_engine #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .RESP_W(RESP_W)
  ) u_engine (
    .clk(clk), .rst(rst), .start(go), .data(reg_wdata), .mosi_rise(go_mosi_rise),
    .miso_rise(go_miso_rise), .nbits(go_nbits), .div(go_div), .miso(eng_miso),
    .sclk(eng_sclk), .mosi(eng_mosi), .cs_n(eng_cs_n), .busy(eng_busy), .resp(eng_resp)
  );

  gspi_pinmux #(
    .PORT_W(PORT_W)
  ) u_pinmux (
    .map(act_map), .sclk(eng_sclk), .mosi(eng_mosi), .cs_n(eng_cs_n),
    .a_in(gpio_a_in), .b_in(gpio_b_in), .a_out(gpio_a_out), .a_oe(gpio_a_oe),
    .b_out(gpio_b_out), .b_oe(gpio_b_oe), .miso(eng_miso)
  );
endmodule

// File: rtl/gspi_checker.sv
module gspi_checker
  import gspi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PORT_W = 12,
  parameter int RESP_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              eng_busy,
  input logic              eng_cs_n,
  input logic              eng_sclk,
  input logic [RESP_W-1:0] eng_resp,
  input pinmap_t           act_map,
  input logic [PORT_W-1:0] gpio_a_oe,
  input logic [PORT_W-1:0] gpio_b_oe
);
  logic              go_wr;
  logic              miso_alone_a;
  logic [PORT_W-1:0] miso_mask_a;

  assign go_wr = reg_wr && (int'(reg_addr) == WORD_GO);
  assign miso_mask_a  = {{(PORT_W-1){1'b0}}, 1'b1} << act_map.miso_pin;
  assign miso_alone_a = (int'(act_map.miso_pin) < PORT_W) &&
                        (act_map.miso_pin != act_map.clk_pin) &&
                        (act_map.miso_pin != act_map.mosi_pin) &&
                        (act_map.miso_pin != act_map.cs_pin);

  // R3: accepted go makes the engine busy next cycle
  assert_go_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (go_wr && !eng_busy) |=> eng_busy);

  // R5: chip-select low exactly while busy
  assert_cs_span_R5: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !eng_cs_n);

  // R5: idle means chip-select high and SCLK low
  assert_idle_lines_R5: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> (eng_cs_n && !eng_sclk));

  // R5: SCLK moves only during a transfer
  assert_sclk_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_sclk != $past(eng_sclk)) |-> $past(eng_busy));

  // R8: response changes only when chip-select rises
  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_resp != $past(eng_resp)) |-> $rose(eng_cs_n));

  // R10: the data-in line is never driven
  assert_miso_input_R10: assert property (@(posedge clk) disable iff (rst)
    miso_alone_a |-> ((gpio_a_oe & miso_mask_a) == '0));

  // R10: at most three enabled outputs
  assert_oe_count_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({gpio_a_oe, gpio_b_oe}) <= 3);
endmodule

bind gpio_spi_master gspi_checker #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .RESP_W(RESP_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .eng_busy(eng_busy), .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk), .eng_resp(eng_resp),
  .act_map(act_map), .gpio_a_oe(gpio_a_oe), .gpio_b_oe(gpio_b_oe)
);

// File: tb/gpio_spi_master_test.sv
`timescale 1ns/1ps
module gpio_spi_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] gpio_a_in = '0, gpio_b_in = '0;
  logic [11:0] gpio_a_out, gpio_a_oe, gpio_b_out, gpio_b_oe;

  int n_cmp = 0, n_bad = 0, cyc = 0, n_starts = 0;
  bit finished = 0;

  // target model configuration
  int m_clk = 31, m_mosi = 31, m_miso = 31, m_cs = 31;
  bit m_mosi_e = 0, m_miso_e = 0;
  logic [31:0] m_tx = '0;

  // scoreboard queues
  logic [31:0] q_mosi[$];
  int          q_n[$];
  int          q_per[$];

  always #2 clk = !clk;

  gpio_spi_master uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_a_in(gpio_a_in), .gpio_a_out(gpio_a_out), .gpio_a_oe(gpio_a_oe),
    .gpio_b_in(gpio_b_in), .gpio_b_out(gpio_b_out), .gpio_b_oe(gpio_b_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // pull-up model: an undriven or invalid pin reads 1
  function automatic logic pin_val(input int idx);
    if (idx >= 0 && idx < 12) return gpio_a_oe[idx] ? gpio_a_out[idx] : 1'b1;
    if (idx >= 16 && idx < 28) return gpio_b_oe[idx-16] ? gpio_b_out[idx-16] : 1'b1;
    return 1'b1;
  endfunction

  function automatic logic [31:0] mk_setup(input bit me, input bit se, input int n,
                                           input int cs, input int mi, input int mo, input int ck);
    return {4'b0, me, se, 6'(n), 5'(cs), 5'(mi), 5'(mo), 5'(ck)};
  endfunction

  // target model / monitor
  logic p_cs = 1'b1, p_s = 1'b0;
  int rises = 0, falls = 0, ptr = 0, t1 = 0, per_meas = 0;
  logic [31:0] cap = '0;

  task automatic drive_miso(input logic v);
    gpio_a_in = '0;
    gpio_b_in = '0;
    if (m_miso >= 0 && m_miso < 12) gpio_a_in[m_miso] = v;
    else if (m_miso >= 16 && m_miso < 28) gpio_b_in[m_miso-16] = v;
  endtask

  function automatic logic tx_bit(input int k);
    return (k < 32) ? m_tx[31-k] : 1'b0;
  endfunction

  always @(negedge clk) begin
    logic c, s, mo;
    cyc++;
    if (!rst) begin
      c  = pin_val(m_cs);
      s  = pin_val(m_clk);
      mo = pin_val(m_mosi);
      if (p_cs && !c) begin
        n_starts++;
        rises = 0; falls = 0; ptr = 0; cap = '0; per_meas = 0;
        if (m_miso_e) begin drive_miso(tx_bit(0)); ptr = 1; end
        else drive_miso(1'b0);
      end else if (!c) begin
        if (s && !p_s) begin
          rises++;
          if (rises == 1) t1 = cyc;
          if (rises == 2) per_meas = cyc - t1;
          if (!m_mosi_e) cap = {cap[30:0], mo};
          if (!m_miso_e) begin drive_miso(tx_bit(ptr)); ptr++; end
        end
        if (!s && p_s) begin
          falls++;
          if (m_mosi_e) cap = {cap[30:0], mo};
          if (m_miso_e) begin drive_miso(tx_bit(ptr)); ptr++; end
        end
      end else if (!p_cs && c) begin
        if (q_n.size() == 0) begin
          chk("R4 unexpected transfer on pins", 32'd1, 32'd0);
        end else begin
          logic [31:0] em;
          int en, ep;
          em = q_mosi.pop_front(); en = q_n.pop_front(); ep = q_per.pop_front();
          chk("R5 rising edge count", rises, en);
          chk("R5 falling edge count", falls, en);
          if (en > 0) chk("R6 payload seen by target", (en < 32) ? (cap & ((32'd1 << en) - 1)) : cap, em);
          if (en >= 2) chk("R11 SCLK period", per_meas, ep);
        end
      end
      p_cs = c;
      p_s  = s;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_ready(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 5000; i++) begin
      rd(6, st);
      if (st[24]) break;
    end
  endtask

  // driver: pushes expected items, starts transfer, checks status
  task automatic xfer(input string tag, input logic [31:0] data, input logic [31:0] tx,
                      input int n, input int per, input bit track);
    logic [31:0] v;
    logic [31:0] rexp;
    m_tx = tx;
    if (track) begin
      q_mosi.push_back((n == 0) ? 32'd0 : (data >> (32 - n)));
      q_n.push_back(n);
      q_per.push_back(per);
    end
    wr(5, data);
    rd(6, v);
    chk({tag, " R3 ready clears after go"}, 32'(v[24]), 32'd0);
    wait_ready(v);
    rexp = (n == 0) ? 32'd0 : ((tx >> (32 - n)) & 32'h00FF_FFFF);
    if (track) chk({tag, " R8 response"}, {8'd0, v[23:0]}, rexp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(6, v); chk("R2 status after reset", v, 32'h0100_0000);
    rd(0, v); chk("R1 setup0 after reset", v, 32'd0);
    rd(4, v); chk("R1 transaction word after reset", v, 32'd0);
    chk("R10 reset output enables A", {20'd0, gpio_a_oe}, 32'h001);
    chk("R10 reset output enables B", {20'd0, gpio_b_oe}, 32'h000);

    // stored bit widths
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R1 setup reserved bits", v, 32'h0FFF_FFFF);
    wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R1 transaction reserved bits", v, 32'h0003_FFFF);
    rd(5, v); chk("R1 go word reads zero", v, 32'd0);

    // slave 0: port A, out on falling, in on rising, 8 bits, div 1
    wr(0, mk_setup(0, 1, 8, 3, 2, 1, 0));
    wr(4, 32'h0000_0001);
    m_clk = 0; m_mosi = 1; m_miso = 2; m_cs = 3; m_mosi_e = 0; m_miso_e = 1;
    @(negedge clk);
    chk("R10 output enables slave0", {20'd0, gpio_a_oe}, 32'h00B);
    chk("R5 idle lines slave0 (CS high, SCLK low)", {20'd0, gpio_a_out & 12'h00B}, 32'h008);
    xfer("s0 mode10", 32'hB400_0000, 32'h5A00_0000, 8, 2, 1);

    // slave 0 again: both on falling, 12 bits, div 5
    wr(0, mk_setup(0, 0, 12, 3, 2, 1, 0));
    wr(4, 32'h0000_0005);
    m_miso_e = 0;
    xfer("s0 mode00 R7", 32'hABC0_0000, 32'h71F0_0000, 12, 6, 1);

    // slave 1: port B, out on rising, in on falling, 16 bits, div 3, plus dropped go
    wr(1, mk_setup(1, 0, 16, 25, 21, 16, 27));
    wr(4, 32'h0001_0003);
    m_clk = 27; m_mosi = 16; m_miso = 21; m_cs = 25; m_mosi_e = 1; m_miso_e = 0;
    m_tx = 32'hBEEF_0000;
    q_mosi.push_back(32'h1234); q_n.push_back(16); q_per.push_back(4);
    wr(5, 32'h1234_FFFF);
    rd(6, v); chk("s1 R3 ready clears after go", 32'(v[24]), 32'd0);
    wr(5, 32'hFFFF_FFFF);
    chk("R10 output enables slave1 port B", {20'd0, gpio_b_oe}, 32'hA01);
    wait_ready(v);
    chk("s1 R6 R8 response", {8'd0, v[23:0]}, 32'h0000_BEEF);
    repeat (40) @(negedge clk);
    chk("R4 dropped go started nothing", n_starts, 3);
    rd(6, v); chk("R4 response kept after dropped go", v, 32'h0100_BEEF);

    // slave 2: mixed ports, both on rising, 32 bits, div 0
    wr(2, mk_setup(1, 1, 32, 10, 16, 23, 3));
    wr(4, 32'h0002_0000);
    m_clk = 3; m_mosi = 23; m_miso = 16; m_cs = 10; m_mosi_e = 1; m_miso_e = 1;
    fork
      xfer("s2 mode11 32-bit", 32'hC0DE_1234, 32'hA5C3_0F96, 32, 2, 1);
      begin
        repeat (6) @(negedge clk);
        chk("R9 mixed-port enables A", {20'd0, gpio_a_oe}, 32'h408);
        chk("R9 mixed-port enables B", {20'd0, gpio_b_oe}, 32'h080);
      end
    join

    // slave 3: chip-select number 12 is invalid
    wr(3, mk_setup(0, 1, 5, 12, 5, 20, 17));
    wr(4, 32'h0003_0002);
    m_clk = 17; m_mosi = 20; m_miso = 5; m_cs = 12;
    fork
      xfer("s3 invalid cs", 32'hF800_0000, 32'h0, 5, 3, 0);
      begin
        repeat (4) @(negedge clk);
        chk("R9 invalid index leaves A undriven", {20'd0, gpio_a_oe}, 32'h000);
        chk("R9 valid B lines enabled", {20'd0, gpio_b_oe}, 32'h012);
      end
    join

    // slave 3: zero length
    wr(3, mk_setup(0, 1, 0, 8, 5, 20, 17));
    m_cs = 8;
    @(negedge clk);
    xfer("s3 zero-length R12", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1);
    repeat (10) @(negedge clk);
    chk("R12 every expected transfer seen", q_n.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule